// File: doc/BRIEF.md
# Quiz Buzzer Arbitration Controller

This block is the control core of an eight-player quiz buzzer. The host sends single-byte commands over a valid/ready input. A start command opens a buzz-in window. The first player whose button rises inside that window takes the question, and every other button is locked out. The winner then has an answer window. Each elapsed window is measured in whole seconds, which are built from an external timer tick. A fixed number of ticks makes one second.

Each time a player takes the buzz, that player's signed score drops by one. A player whose score goes below zero is eliminated, and that player's button is masked for the rest of the game. Round outcomes leave as one-cycle event bytes:

- the winner's digit,
- a buzz timeout,
- an answer overtime,
- a next-question acknowledgement,
- game over.

On the end command the block scans all scores and shows the highest scorer on the display outputs. Two lamps are driven: an alarm lamp that lights when a window runs out, and a hold lamp that stays lit while a player holds the question.

Top module: `quiz_buzzer_ctrl`

## Requirements
- R1: In the idle state, command byte 0x6B opens the buzz-in window. The first rising button edge inside the window emits event byte 0x30+n, where n is the player number from 1 to 8 and button bit n-1 belongs to player n. The event appears one clock after the edge is sampled.
- R2: When several buttons rise in the same clock, the lowest-numbered player wins.
- R3: After a win, presses by any player are ignored until the next round. Presses while idle are also ignored. A button already held when the window opens does not count, because only a rising edge counts.
- R4: If nobody buzzes within BUZZ_SEC*TICKS_PER_SEC ticks, the block emits event 0x54 and lights the alarm lamp, and no score changes.
- R5: If the answer window of ANSWER_SEC*TICKS_PER_SEC ticks runs out, the block emits event 0x56, lights the alarm lamp, turns off the hold lamp and returns to idle.
- R6: A win decrements the winner's score by one in the same clock as the event. The display shows the winner's number and new score. The hold lamp is lit for the whole answer window.
- R7: A player whose score falls below zero gets elim_o bit n-1 set. That bit stays set, and the player's button can never win again.
- R8: Command byte 0x6E during the answer window ends the round early, emits event 0x4E and returns to idle.
- R9: Command byte 0x65 in the idle state starts a score scan. cmd_ready_o is low during the scan. The scan then emits event 0x45 and shows the highest score and its player number, with ties going to the lowest number. After that, further commands are ignored.
- R10: After reset, all scores equal INIT_SCORE and no player is eliminated. Both lamps are off, the display player is 0, no event is valid, and cmd_ready_o is high.
- R11: The alarm lamp stays lit until the next start command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, which also resets scores |
| tick_i | input | 1 | Timer overflow tick, one cycle per tick |
| btn_i | input | 8 | Debounced player buttons; bit n-1 is player n |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_data_i | input | 8 | Command byte |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| evt_valid_o | output | 1 | One-cycle event strobe |
| evt_data_o | output | 8 | Event byte |
| alarm_lamp_o | output | 1 | Window-expired lamp |
| hold_lamp_o | output | 1 | Player-holds-question lamp |
| disp_player_o | output | 4 | Displayed player number, 0 when none |
| disp_score_o | output | 8 | Displayed signed score |
| elim_o | output | 8 | Eliminated flags per player |

## Verification
The hardest state to reach is a masked button, because it exists only after one player has won often enough to go below zero. The stimulus table therefore repeats the same player's press across rounds until that score reaches -1. The next table entry then presses the eliminated player together with a higher-numbered player, and the higher-numbered player must win. Both window timeouts are measured by counting clocks under a constant tick. During those waits a button is kept held from before the window opened, and another player presses while the question is held.

// File: rtl/quiz_pkg.sv
// Shared types and byte codes for the quiz buzzer controller.
package quiz_pkg;
    typedef logic signed [7:0] score_t;

    localparam logic [7:0] CMD_START    = 8'h6B;
    localparam logic [7:0] CMD_NEXT     = 8'h6E;
    localparam logic [7:0] CMD_END      = 8'h65;
    localparam logic [7:0] EVT_TIMEOUT  = 8'h54;
    localparam logic [7:0] EVT_OVERTIME = 8'h56;
    localparam logic [7:0] EVT_NEXT     = 8'h4E;
    localparam logic [7:0] EVT_END      = 8'h45;
    localparam logic [7:0] EVT_DIGIT0   = 8'h30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUZZ,
        ST_ANSWER,
        ST_SCAN,
        ST_DONE
    } qb_state_e;
endpackage

// File: rtl/qb_timebase.sv
// Seconds divider: gives a one-cycle pulse on every TICKS_PER_SEC-th tick.
// Assumes tick_i is a single-cycle strobe; clr_i restarts the count at zero.
module qb_timebase #(
    parameter int TICKS_PER_SEC = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic sec_o
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    // Pulse when the final tick of a second arrives.
    assign sec_o = tick_i && !clr_i && (cnt_q == LAST);

    // Count ticks within the current second.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/qb_arbiter.sv
// First-press detector: finds rising button edges, drops masked players,
// and picks the lowest index when several rise together.
// Assumes buttons are already debounced and synchronous to clk.
module qb_arbiter #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic [N-1:0]  btn_i,
    input  logic [N-1:0]  mask_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;

    // Remember last button levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= btn_i;
    end

    assign rise  = btn_i & ~prev_q & ~mask_i;
    assign hit_o = arm_i && (|rise);

    // Fixed priority: scanning downward leaves the lowest set index.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rise[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/qb_scoreboard.sv
// Per-player signed score registers with elimination flags.
// Assumes dec_i is raised only for a player who is not eliminated,
// and INIT_SCORE is non-negative and fits in a signed byte.
module qb_scoreboard
    import quiz_pkg::*;
#(
    parameter int N          = 8,
    parameter int IW         = 3,
    parameter int INIT_SCORE = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dec_i,
    input  logic [IW-1:0]        dec_idx_i,
    output score_t [N-1:0]       scores_o,
    output logic   [N-1:0]       elim_o
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        score_t score_q;
        logic   elim_q;

        // Decrement this slot on a win; flag it once it drops below zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                score_q <= score_t'(INIT_SCORE);
                elim_q  <= 1'b0;
            end else if (dec_i && dec_idx_i == IW'(g)) begin
                score_q <= score_q - score_t'(1);
                if (score_q <= score_t'(0)) elim_q <= 1'b1;
            end
        end

        assign scores_o[g] = score_q;
        assign elim_o[g]   = elim_q;
    end
endmodule

// File: rtl/qb_maxscan.sv
// Sequential highest-score search, one slot per clock.
// Strict comparison keeps the lowest index on ties. Takes N cycles after start_i.
module qb_maxscan
    import quiz_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  score_t [N-1:0] scores_i,
    output logic           done_o,
    output logic [IW-1:0]  best_idx_o
);
    logic    busy_q;
    logic [IW-1:0] ptr_q;
    score_t  best_q;

    // Walk the score slots and keep the running maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            ptr_q      <= '0;
            best_q     <= '0;
            best_idx_o <= '0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                busy_q     <= 1'b1;
                ptr_q      <= IW'(1);
                best_q     <= scores_i[0];
                best_idx_o <= '0;
            end else if (busy_q) begin
                if ($signed(scores_i[ptr_q]) > $signed(best_q)) begin
                    best_q     <= scores_i[ptr_q];
                    best_idx_o <= ptr_q;
                end
                if (ptr_q == IW'(N - 1)) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    ptr_q <= ptr_q + IW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/quiz_buzzer_ctrl.sv
// Round controller for the quiz buzzer. It sequences idle, buzz window,
// answer window, end-of-game scan and done. It decodes command bytes and
// issues event bytes.
// Assumes N_PLAYERS is at most 9, so event digits stay single ASCII characters.
module quiz_buzzer_ctrl
    import quiz_pkg::*;
#(
    parameter int N_PLAYERS     = 8,
    parameter int TICKS_PER_SEC = 38,
    parameter int BUZZ_SEC      = 5,
    parameter int ANSWER_SEC    = 10,
    parameter int INIT_SCORE    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [N_PLAYERS-1:0]  btn_i,
    input  logic                  cmd_valid_i,
    input  logic [7:0]            cmd_data_i,
    output logic                  cmd_ready_o,
    output logic                  evt_valid_o,
    output logic [7:0]            evt_data_o,
    output logic                  alarm_lamp_o,
    output logic                  hold_lamp_o,
    output logic [$clog2(N_PLAYERS+1)-1:0] disp_player_o,
    output logic [7:0]            disp_score_o,
    output logic [N_PLAYERS-1:0]  elim_o
);
    localparam int IW   = (N_PLAYERS > 1) ? $clog2(N_PLAYERS) : 1;
    localparam int PNW  = $clog2(N_PLAYERS + 1);
    localparam int WMAX = (BUZZ_SEC > ANSWER_SEC) ? BUZZ_SEC : ANSWER_SEC;
    localparam int SW   = $clog2(WMAX + 1);
    localparam logic [SW-1:0] BUZZ_LAST = SW'(BUZZ_SEC - 1);
    localparam logic [SW-1:0] ANS_LAST  = SW'(ANSWER_SEC - 1);

    qb_state_e state_q;
    logic [SW-1:0] sec_cnt_q;
    logic [IW-1:0] disp_idx_q;
    logic          disp_valid_q;
    logic          alarm_q;

    logic          in_window, sec_pulse, tb_clr;
    logic          hit, win_dec, scan_start, scan_done;
    logic [IW-1:0] hit_idx, best_idx;
    logic          cmd_fire;
    logic [SW-1:0] win_last;
    score_t [N_PLAYERS-1:0] scores;

    assign cmd_ready_o = (state_q != ST_SCAN);
    assign cmd_fire    = cmd_valid_i && cmd_ready_o;
    assign in_window   = (state_q == ST_BUZZ) || (state_q == ST_ANSWER);
    assign win_dec     = (state_q == ST_BUZZ) && hit;
    assign tb_clr      = !in_window || win_dec;
    assign scan_start  = (state_q == ST_IDLE) && cmd_fire && (cmd_data_i == CMD_END);
    assign win_last    = (state_q == ST_ANSWER) ? ANS_LAST : BUZZ_LAST;

    qb_timebase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tb (
        .clk(clk), .rst_n(rst_n), .clr_i(tb_clr),
        .tick_i(tick_i && in_window), .sec_o(sec_pulse)
    );

    qb_arbiter #(.N(N_PLAYERS), .IW(IW)) u_arb (
        .clk(clk), .rst_n(rst_n), .arm_i(state_q == ST_BUZZ),
        .btn_i(btn_i), .mask_i(elim_o), .hit_o(hit), .idx_o(hit_idx)
    );

    qb_scoreboard #(.N(N_PLAYERS), .IW(IW), .INIT_SCORE(INIT_SCORE)) u_sb (
        .clk(clk), .rst_n(rst_n), .dec_i(win_dec), .dec_idx_i(hit_idx),
        .scores_o(scores), .elim_o(elim_o)
    );

    qb_maxscan #(.N(N_PLAYERS), .IW(IW)) u_scan (
        .clk(clk), .rst_n(rst_n), .start_i(scan_start), .scores_i(scores),
        .done_o(scan_done), .best_idx_o(best_idx)
    );

    // Round sequencing, window timing and event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            sec_cnt_q    <= '0;
            disp_idx_q   <= '0;
            disp_valid_q <= 1'b0;
            alarm_q      <= 1'b0;
            evt_valid_o  <= 1'b0;
            evt_data_o   <= '0;
        end else begin
            evt_valid_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_fire && cmd_data_i == CMD_START) begin
                        state_q   <= ST_BUZZ;
                        sec_cnt_q <= '0;
                        alarm_q   <= 1'b0;
                    end else if (scan_start) begin
                        state_q <= ST_SCAN;
                    end
                end
                ST_BUZZ: begin
                    if (hit) begin
                        state_q      <= ST_ANSWER;
                        sec_cnt_q    <= '0;
                        disp_idx_q   <= hit_idx;
                        disp_valid_q <= 1'b1;
                        evt_valid_o  <= 1'b1;
                        evt_data_o   <= EVT_DIGIT0 + 8'(hit_idx) + 8'd1;
                    end else if (sec_pulse) begin
                        if (sec_cnt_q == win_last) begin
                            state_q     <= ST_IDLE;
                            alarm_q     <= 1'b1;
                            evt_valid_o <= 1'b1;
                            evt_data_o  <= EVT_TIMEOUT;
                        end else begin
                            sec_cnt_q <= sec_cnt_q + SW'(1);
                        end
                    end
                end
                ST_ANSWER: begin
                    if (cmd_fire && cmd_data_i == CMD_NEXT) begin
                        state_q     <= ST_IDLE;
                        evt_valid_o <= 1'b1;
                        evt_data_o  <= EVT_NEXT;
                    end else if (sec_pulse) begin
                        if (sec_cnt_q == win_last) begin
                            state_q     <= ST_IDLE;
                            alarm_q     <= 1'b1;
                            evt_valid_o <= 1'b1;
                            evt_data_o  <= EVT_OVERTIME;
                        end else begin
                            sec_cnt_q <= sec_cnt_q + SW'(1);
                        end
                    end
                end
                ST_SCAN: begin
                    if (scan_done) begin
                        state_q      <= ST_DONE;
                        disp_idx_q   <= best_idx;
                        disp_valid_q <= 1'b1;
                        evt_valid_o  <= 1'b1;
                        evt_data_o   <= EVT_END;
                    end
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    assign alarm_lamp_o  = alarm_q;
    assign hold_lamp_o   = (state_q == ST_ANSWER);
    assign disp_player_o = disp_valid_q ? (PNW'(disp_idx_q) + PNW'(1)) : '0;
    assign disp_score_o  = disp_valid_q ? scores[disp_idx_q] : 8'd0;
endmodule

// File: rtl/quiz_buzzer_ctrl_chk.sv
// Property checker for quiz_buzzer_ctrl, bound to every instance.
// Observes ports only.
module quiz_buzzer_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         evt_valid_o,
    input logic [7:0]   evt_data_o,
    input logic         alarm_lamp_o,
    input logic         hold_lamp_o,
    input logic [$clog2(N+1)-1:0] disp_player_o,
    input logic [N-1:0] elim_o
);
    logic digit_evt;
    assign digit_evt = evt_valid_o && (evt_data_o >= 8'h31) && (evt_data_o <= 8'h30 + 8'(N));

    // R1
    digit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_evt |-> hold_lamp_o);

    // R6
    hold_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_lamp_o |-> (disp_player_o != '0));

    // R3
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_lamp_o && $past(hold_lamp_o)) |-> $stable(disp_player_o));

    // R7
    elim_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elim_o & $past(elim_o)) == $past(elim_o));

    // R7
    masked_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_evt |-> ((($past(elim_o)) >> (evt_data_o - 8'h31)) & N'(1)) == '0);

    // R4
    alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_lamp_o) |-> (evt_valid_o && (evt_data_o == 8'h54 || evt_data_o == 8'h56)));
endmodule

bind quiz_buzzer_ctrl quiz_buzzer_ctrl_chk #(.N(N_PLAYERS)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_valid_o(evt_valid_o), .evt_data_o(evt_data_o),
    .alarm_lamp_o(alarm_lamp_o), .hold_lamp_o(hold_lamp_o),
    .disp_player_o(disp_player_o), .elim_o(elim_o)
);

// File: tb/quiz_buzzer_ctrl_bench.sv
module quiz_buzzer_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] btn = '0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       cmd_ready, evt_valid, alarm, hold;
    logic [7:0] evt_data, disp_score, elim;
    logic [3:0] disp_player;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    quiz_buzzer_ctrl #(
        .N_PLAYERS(8), .TICKS_PER_SEC(3), .BUZZ_SEC(2), .ANSWER_SEC(2), .INIT_SCORE(2)
    ) u_quiz_buzzer_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_i(btn),
        .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data), .cmd_ready_o(cmd_ready),
        .evt_valid_o(evt_valid), .evt_data_o(evt_data), .alarm_lamp_o(alarm),
        .hold_lamp_o(hold), .disp_player_o(disp_player), .disp_score_o(disp_score),
        .elim_o(elim)
    );

    // Fields: button mask, expected winner number, expected score after win.
    localparam logic [23:0] VEC [7] = '{
        {8'h10, 8'd5, 8'sd1},
        {8'h06, 8'd2, 8'sd1},
        {8'h81, 8'd1, 8'sd1},
        {8'h10, 8'd5, 8'sd0},
        {8'h10, 8'd5, -8'sd1},
        {8'h30, 8'd6, 8'sd1},
        {8'h02, 8'd2, 8'sd0}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        cmd_valid = 1'b1;
        cmd_data  = b;
        step();
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int waited;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10 reset state
        chk("R10 evt_valid", int'(evt_valid), 0);
        chk("R10 lamps", int'({alarm, hold}), 0);
        chk("R10 disp_player", int'(disp_player), 0);
        chk("R10 elim", int'(elim), 0);
        chk("R10 ready", int'(cmd_ready), 1);

        // R1 R2 R6 R7 R8 table-driven rounds
        foreach (VEC[i]) begin
            send(8'h6B);
            chk("R1 no event on start", int'(evt_valid), 0);
            btn = VEC[i][23:16];
            step();
            chk("R1/R2 winner event", int'(evt_data) & {32{evt_valid}}, 32'h30 + int'(VEC[i][15:8]));
            chk("R6 disp player", int'(disp_player), int'(VEC[i][15:8]));
            chk("R6 disp score", int'($signed(disp_score)), int'($signed(VEC[i][7:0])));
            chk("R6 hold lamp", int'(hold), 1);
            btn = '0;
            step();
            chk("R1 event is one cycle", int'(evt_valid), 0);
            send(8'h6E);
            chk("R8 next event", int'(evt_data) & {32{evt_valid}}, 32'h4E);
            chk("R8 hold off", int'(hold), 0);
        end
        chk("R7 elimination flag", int'(elim), 32'h10);

        // R5 R3 overtime with a lockout press
        send(8'h6B);
        btn = 8'h04;
        step();
        chk("R1 player 3 event", int'(evt_data) & {32{evt_valid}}, 32'h33);
        btn = '0;
        tick = 1'b1;
        waited = 0;
        for (int n = 1; n <= 20; n++) begin
            btn = (n == 2) ? 8'h80 : 8'h00;
            step();
            waited = n;
            if (evt_valid) break;
        end
        btn = '0;
        tick = 1'b0;
        chk("R5 answer window length", waited, 6);
        chk("R5 overtime event", int'(evt_data), 32'h56);
        chk("R5 alarm lamp", int'(alarm), 1);
        chk("R5 hold off", int'(hold), 0);
        chk("R3 lockout kept winner", int'(disp_player), 3);

        // R11 alarm cleared by start; R4 timeout with a button held from idle
        btn = 8'h40;
        step();
        send(8'h6B);
        chk("R11 alarm cleared", int'(alarm), 0);
        tick = 1'b1;
        waited = 0;
        for (int n = 1; n <= 20; n++) begin
            step();
            waited = n;
            if (evt_valid) break;
        end
        tick = 1'b0;
        chk("R4 buzz window length", waited, 6);
        chk("R3/R4 timeout event", int'(evt_data), 32'h54);
        chk("R4 alarm lamp", int'(alarm), 1);
        chk("R4 score unchanged", int'($signed(disp_score)), 1);
        btn = '0;
        step();

        // R3 press while idle ignored
        btn = 8'h80;
        step();
        chk("R3 idle press ignored", int'(evt_valid), 0);
        chk("R3 idle display unchanged", int'(disp_player), 3);
        btn = '0;
        step();

        // R9 end of game scan
        send(8'h65);
        chk("R9 ready low during scan", int'(cmd_ready), 0);
        waited = 0;
        for (int n = 1; n <= 20; n++) begin
            if (evt_valid) break;
            step();
            waited = n;
        end
        chk("R9 end event", int'(evt_data) & {32{evt_valid}}, 32'h45);
        chk("R9 best player", int'(disp_player), 4);
        chk("R9 best score", int'($signed(disp_score)), 2);
        step();
        send(8'h6B);
        chk("R9 start ignored after end", int'(evt_valid), 0);
        step();
        chk("R9 display held", int'(disp_player), 4);
        chk("R9 ready high after end", int'(cmd_ready), 1);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule